// File: doc/BRIEF.md
# Static Branch Predictor with Speculation Guard

This block sits between instruction decode and the fetch unit of a pipelined core. When decode presents a conditional branch, the block forms a fixed taken/not-taken guess in the same cycle. It picks the guess with one of three selectable static policies. The policies are: never taken; taken when the target lies below the branch (a backward jump, typical of loops); or follow a hint bit placed in the instruction by the compiler. If the guess is taken, fetch is steered to the target at once. Otherwise fetch carries on sequentially.

From the cycle after a branch is accepted until execute reports its outcome, every instruction that follows is on a guessed path. During that window the block holds its commit-enable low, so no register or memory write from the guessed path can retire. When execute resolves the branch, the block compares the real outcome with the stored guess. If the guess was right, commit is released. If it was wrong, the block raises a flush for the younger instructions in fetch and decode and redirects fetch to the correct address: the target if the branch was taken, or the branch address plus one instruction (4 bytes) if it was not.

Only one branch may be unresolved at a time. A second branch that reaches decode while the first is still open is stalled. Two saturating-free wrap counters report how many branches were accepted and how many were mispredicted.

Top module: `static_branch_guard`

## Requirements
- R1: With `policy_sel` = 2'b00, or the reserved code 2'b11, every accepted branch is predicted not taken: `pred_taken` is 0 and no redirect is issued for it.
- R2: With `policy_sel` = 2'b01, an accepted branch is predicted taken exactly when `dec_target` is numerically lower than `dec_pc` (unsigned); an equal or higher target is predicted not taken.
- R3: With `policy_sel` = 2'b10, the prediction of an accepted branch equals `dec_hint`.
- R4: A branch predicted taken drives `redir_valid` = 1 and `redir_addr` = `dec_target` in the cycle it is decoded; one predicted not taken drives no redirect.
- R5: From the cycle after a branch is accepted until the cycle its resolution arrives, `commit_en` is 0. It is 1 otherwise, except in a mispredict cycle.
- R6: A resolution whose outcome differs from the stored prediction raises `flush` and `redir_valid` in that cycle, with `redir_addr` equal to the target when taken and the branch PC + 4 when not taken; `commit_en` is 0 in that cycle.
- R7: A resolution that matches the prediction raises neither `flush` nor a redirect and sets `commit_en` to 1 in the same cycle.
- R8: A branch decoded while another is unresolved and not resolving in that cycle raises `stall` and is not accepted: it issues no redirect and does not change `br_count`.
- R9: `br_count` increments by one, one cycle after each accepted branch. `mispred_count` increments by one, one cycle after each flush.
- R10: A resolution pulse with no branch outstanding is ignored: no flush, no redirect, the counters unchanged, `commit_en` stays 1.
- R11: When a branch is decoded in the same cycle the outstanding one resolves, the new branch is accepted without a stall if the older prediction was right. If it was wrong, the new branch is dropped as wrong-path, is not counted, and the redirect carries the older branch's correct address.
- R12: After reset, `commit_en` is 1, `flush`, `stall` and `redir_valid` are 0, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| policy_sel | input | 2 | Static policy: 00 never taken, 01 backward taken, 10 hint, 11 treated as 00 |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_is_branch | input | 1 | The decoded instruction is a conditional branch |
| dec_pc | input | AW | Address of the decoded branch |
| dec_target | input | AW | Branch target address |
| dec_hint | input | 1 | Compiler hint bit, 1 = likely taken |
| ex_resolve | input | 1 | Execute reports the outcome of the outstanding branch |
| ex_taken | input | 1 | Actual outcome, 1 = taken |
| pred_taken | output | 1 | Prediction for the branch in decode |
| stall | output | 1 | Decode must hold its branch this cycle |
| redir_valid | output | 1 | Fetch must restart at `redir_addr` |
| redir_addr | output | AW | New fetch address |
| flush | output | 1 | Discard younger instructions in fetch and decode |
| commit_en | output | 1 | Writes of retiring instructions are permitted |
| br_count | output | CW | Number of accepted branches |
| mispred_count | output | CW | Number of mispredictions |

## Verification
The collision that matters is a new branch arriving in decode in the same cycle that execute resolves the outstanding one, so that a predicted redirect and a correction redirect contend for the fetch port. The bench holds a branch open, then presents a second branch whose own prediction is taken toward a distinct target together with the resolution. It does this once with a correct older guess, expecting the newcomer to be accepted, counted and to own the redirect. It does it once with a wrong older guess, expecting the flush, the older branch's correct address, and an unchanged branch count.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    POL_NEVER    = 2'b00,
    POL_BACKWARD = 2'b01,
    POL_HINT     = 2'b10,
    POL_RESERVED = 2'b11
  } policy_e;

  localparam int unsigned CNT_BRANCH  = 0;
  localparam int unsigned CNT_MISPRED = 1;
  localparam int unsigned NUM_CNT     = 2;
endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bp_policy.sv
module bp_policy #(
  parameter int unsigned AW = 32
) (
  input  logic [1:0]    policy_sel,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  input  logic          hint,
  output logic          taken
);
  import bp_pkg::*;

  policy_e pol;
  logic    backward;

  assign pol      = policy_e'(policy_sel);
  assign backward = (target < pc);

  always_comb begin
    unique case (pol)
      POL_BACKWARD: taken = backward;
      POL_HINT:     taken = hint;
      default:      taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/bp_spec_tracker.sv
module bp_spec_tracker #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_en,
  input  logic          close_en,
  input  logic          open_pred,
  input  logic [AW-1:0] open_pc,
  input  logic [AW-1:0] open_target,
  output logic          pend,
  output logic          pend_pred,
  output logic [AW-1:0] pend_pc,
  output logic [AW-1:0] pend_target
);
  logic          pend_d, pred_d;
  logic [AW-1:0] pc_d, tgt_d;
  logic          info_en;

  assign info_en = open_en;

  always_comb begin
    pend_d = pend;
    if (open_en)       pend_d = 1'b1;
    else if (close_en) pend_d = 1'b0;
    pred_d = open_pred;
    pc_d   = open_pc;
    tgt_d  = open_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_pred   <= 1'b0;
      pend_pc     <= '0;
      pend_target <= '0;
    end else if (info_en) begin
      pend_pred   <= pred_d;
      pend_pc     <= pc_d;
      pend_target <= tgt_d;
    end
  end
endmodule

// File: rtl/bp_event_counters.sv
module bp_event_counters #(
  parameter int unsigned N  = 2,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  inc,
  output logic [N*CW-1:0] counts
);
  localparam logic [CW-1:0] ONE = CW'(1);

  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (inc[i]) cnt_q <= cnt_d;
    end

    assign counts[i*CW +: CW] = cnt_q;
  end
endmodule

// File: rtl/static_branch_guard.sv
module static_branch_guard #(
  parameter int unsigned AW          = 32,
  parameter int unsigned CW          = 16,
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    policy_sel,
  input  logic          dec_valid,
  input  logic          dec_is_branch,
  input  logic [AW-1:0] dec_pc,
  input  logic [AW-1:0] dec_target,
  input  logic          dec_hint,
  input  logic          ex_resolve,
  input  logic          ex_taken,
  output logic          pred_taken,
  output logic          stall,
  output logic          redir_valid,
  output logic [AW-1:0] redir_addr,
  output logic          flush,
  output logic          commit_en,
  output logic [CW-1:0] br_count,
  output logic [CW-1:0] mispred_count
);
  import bp_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

  logic          rst_n_s;
  logic          br_seen, resolving, mispredict, accept, guess;
  logic          pend, pend_pred;
  logic [AW-1:0] pend_pc, pend_target, fix_addr;
  logic [NUM_CNT-1:0]    cnt_inc;
  logic [NUM_CNT*CW-1:0] cnt_bus;

  bp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  bp_policy #(.AW(AW)) u_pol (
    .policy_sel(policy_sel), .pc(dec_pc), .target(dec_target),
    .hint(dec_hint), .taken(guess)
  );

  always_comb begin
    br_seen    = dec_valid & dec_is_branch;
    resolving  = ex_resolve & pend;
    mispredict = resolving & (ex_taken != pend_pred);
    accept     = br_seen & ~mispredict & (~pend | resolving);
    fix_addr   = ex_taken ? pend_target : (pend_pc + STEP);
  end

  bp_spec_tracker #(.AW(AW)) u_trk (
    .clk(clk), .rst_n(rst_n_s),
    .open_en(accept), .close_en(resolving),
    .open_pred(guess), .open_pc(dec_pc), .open_target(dec_target),
    .pend(pend), .pend_pred(pend_pred), .pend_pc(pend_pc),
    .pend_target(pend_target)
  );

  always_comb begin
    cnt_inc              = '0;
    cnt_inc[CNT_BRANCH]  = accept;
    cnt_inc[CNT_MISPRED] = mispredict;
  end

  bp_event_counters #(.N(NUM_CNT), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .inc(cnt_inc), .counts(cnt_bus)
  );

  always_comb begin
    pred_taken    = br_seen & guess;
    stall         = br_seen & pend & ~resolving;
    flush         = mispredict;
    commit_en     = ~pend | (resolving & ~mispredict);
    redir_valid   = mispredict | (accept & guess);
    redir_addr    = mispredict ? fix_addr : dec_target;
    br_count      = cnt_bus[CNT_BRANCH*CW +: CW];
    mispred_count = cnt_bus[CNT_MISPRED*CW +: CW];
  end
endmodule

// File: rtl/bp_guard_checker.sv
module bp_guard_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    policy_sel,
  input logic          dec_valid,
  input logic          dec_is_branch,
  input logic [AW-1:0] dec_pc,
  input logic [AW-1:0] dec_target,
  input logic          dec_hint,
  input logic          pred_taken,
  input logic          stall,
  input logic          redir_valid,
  input logic [AW-1:0] redir_addr,
  input logic          flush,
  input logic          commit_en,
  input logic [CW-1:0] br_count,
  input logic [CW-1:0] mispred_count
);
  logic fresh;
  assign fresh = dec_valid && dec_is_branch && !stall && !flush;

  assert_never_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && (policy_sel == 2'b00 || policy_sel == 2'b11) |-> !pred_taken);

  assert_backward_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && policy_sel == 2'b01 |-> pred_taken == (dec_target < dec_pc));

  assert_hint_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && policy_sel == 2'b10 |-> pred_taken == dec_hint);

  assert_taken_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && pred_taken |-> redir_valid && redir_addr == dec_target);

  assert_flush_blocks_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> redir_valid && !commit_en);

  assert_stall_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> br_count == $past(br_count));

  assert_flush_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> mispred_count == $past(mispred_count) + CW'(1));
endmodule

bind static_branch_guard bp_guard_checker #(.AW(AW), .CW(CW)) u_guard_chk (
  .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .dec_valid(dec_valid),
  .dec_is_branch(dec_is_branch), .dec_pc(dec_pc), .dec_target(dec_target),
  .dec_hint(dec_hint), .pred_taken(pred_taken), .stall(stall),
  .redir_valid(redir_valid), .redir_addr(redir_addr), .flush(flush),
  .commit_en(commit_en), .br_count(br_count), .mispred_count(mispred_count)
);

// File: tb/tb_static_branch_guard.sv
module tb_static_branch_guard;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    policy_sel;
  logic          dec_valid, dec_is_branch, dec_hint;
  logic [AW-1:0] dec_pc, dec_target;
  logic          ex_resolve, ex_taken;
  logic          pred_taken, stall, redir_valid, flush, commit_en;
  logic [AW-1:0] redir_addr;
  logic [CW-1:0] br_count, mispred_count;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_br   = 0;
  int exp_mp   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  static_branch_guard #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .dec_valid(dec_valid),
    .dec_is_branch(dec_is_branch), .dec_pc(dec_pc), .dec_target(dec_target),
    .dec_hint(dec_hint), .ex_resolve(ex_resolve), .ex_taken(ex_taken),
    .pred_taken(pred_taken), .stall(stall), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .flush(flush), .commit_en(commit_en),
    .br_count(br_count), .mispred_count(mispred_count)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    dec_valid = 0; dec_is_branch = 0; dec_hint = 0;
    dec_pc = '0; dec_target = '0; ex_resolve = 0; ex_taken = 0;
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic put_branch(input logic [1:0] m, input logic [AW-1:0] pc,
                            input logic [AW-1:0] tgt, input logic h);
    policy_sel = m; dec_valid = 1; dec_is_branch = 1;
    dec_pc = pc; dec_target = tgt; dec_hint = h;
  endtask

  task automatic check_counts(input string req);
    check({req, " br_count"}, 64'(br_count), 64'(exp_br));
    check({req, " mispred_count"}, 64'(mispred_count), 64'(exp_mp));
  endtask

  // One branch: decode, hold open, resolve, then check counters.
  task automatic run_branch(input string req, input logic [1:0] m,
                            input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                            input logic h, input logic exp_pred, input logic actual);
    logic wrong;
    wrong = (actual != exp_pred);
    next_cycle();
    put_branch(m, pc, tgt, h);
    #2;
    check({req, " prediction"}, 64'(pred_taken), 64'(exp_pred));
    check("R4 decode redirect", 64'(redir_valid), 64'(exp_pred));
    if (exp_pred) check("R4 redirect target", 64'(redir_addr), 64'(tgt));
    next_cycle();
    idle_inputs();
    exp_br++;
    #1;
    check("R5 commit held while open", 64'(commit_en), 64'd0);
    ex_resolve = 1; ex_taken = actual;
    #1;
    if (wrong) begin
      check("R6 flush", 64'(flush), 64'd1);
      check("R6 redirect", 64'(redir_valid), 64'd1);
      check("R6 correct addr", 64'(redir_addr), actual ? 64'(tgt) : 64'(pc + 4));
      check("R6 commit blocked", 64'(commit_en), 64'd0);
      exp_mp++;
    end else begin
      check("R7 no flush", 64'(flush), 64'd0);
      check("R7 no redirect", 64'(redir_valid), 64'd0);
      check("R7 commit released", 64'(commit_en), 64'd1);
    end
    next_cycle();
    idle_inputs();
    #2;
    check_counts("R9");
    check("R5 commit after resolve", 64'(commit_en), 64'd1);
  endtask

  task automatic t_reset();
    next_cycle(); #2;
    check("R12 commit_en", 64'(commit_en), 64'd1);
    check("R12 flush", 64'(flush), 64'd0);
    check("R12 stall", 64'(stall), 64'd0);
    check("R12 redir_valid", 64'(redir_valid), 64'd0);
    check_counts("R12");
  endtask

  task automatic t_never();
    run_branch("R1 mode00", 2'b00, 32'h100, 32'h80, 1'b1, 1'b0, 1'b0);
    run_branch("R1 mode11", 2'b11, 32'h200, 32'h40, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_backward();
    run_branch("R2 backward", 2'b01, 32'h300, 32'h2F0, 1'b0, 1'b1, 1'b1);
    run_branch("R2 forward",  2'b01, 32'h300, 32'h400, 1'b1, 1'b0, 1'b0);
    run_branch("R2 equal",    2'b01, 32'h300, 32'h300, 1'b1, 1'b0, 1'b0);
    run_branch("R2 back miss", 2'b01, 32'h500, 32'h100, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_hint();
    run_branch("R3 hint1", 2'b10, 32'h600, 32'h700, 1'b1, 1'b1, 1'b1);
    run_branch("R3 hint0", 2'b10, 32'h600, 32'h100, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_stall();
    next_cycle();
    put_branch(2'b00, 32'h1000, 32'h1100, 1'b0);
    next_cycle();
    exp_br++;
    put_branch(2'b10, 32'h1004, 32'h2000, 1'b1);
    #2;
    check("R8 stall raised", 64'(stall), 64'd1);
    check("R8 no redirect", 64'(redir_valid), 64'd0);
    next_cycle();
    #2;
    check("R8 count unchanged", 64'(br_count), 64'(exp_br));
    ex_resolve = 1; ex_taken = 0;
    #1;
    check("R11 accepted on good resolve", 64'(stall), 64'd0);
    check("R11 newcomer redirect", 64'(redir_addr), 64'h2000);
    next_cycle();
    exp_br++;
    idle_inputs();
    ex_resolve = 1; ex_taken = 1;
    #2;
    check("R7 second branch correct", 64'(flush), 64'd0);
    next_cycle();
    idle_inputs();
    #2;
    check_counts("R11");
  endtask

  task automatic t_collision_wrong();
    next_cycle();
    put_branch(2'b00, 32'h3000, 32'h3400, 1'b0);
    next_cycle();
    exp_br++;
    put_branch(2'b10, 32'h3004, 32'h5000, 1'b1);
    ex_resolve = 1; ex_taken = 1;
    #2;
    check("R11 flush wins", 64'(flush), 64'd1);
    check("R11 older correct addr", 64'(redir_addr), 64'h3400);
    check("R11 no stall", 64'(stall), 64'd0);
    exp_mp++;
    next_cycle();
    idle_inputs();
    #2;
    check_counts("R11 dropped");
    check("R11 nothing open", 64'(commit_en), 64'd1);
  endtask

  task automatic t_stray();
    next_cycle();
    ex_resolve = 1; ex_taken = 1;
    #2;
    check("R10 no flush", 64'(flush), 64'd0);
    check("R10 no redirect", 64'(redir_valid), 64'd0);
    check("R10 commit", 64'(commit_en), 64'd1);
    next_cycle();
    idle_inputs();
    #2;
    check_counts("R10");
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    policy_sel = 2'b00;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_never();
    t_backward();
    t_hint();
    t_stall();
    t_collision_wrong();
    t_stray();
    next_cycle();
    finish_run();
  end
endmodule